// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This block adds or subtracts two 32-bit binary floating-point numbers laid out as one sign bit, an 8-bit exponent biased by 127 and a 23-bit fraction with an implied leading one. The result is produced by a fixed sequence of steps. The unit restores the hidden bit, shifts the operand with the smaller exponent right, and then adds or subtracts the significands. Next it normalizes the sum in either direction, and last it rounds to nearest with ties to even. Subtraction reuses the adder: the sign of the second operand is flipped before the operands are unpacked.

The unit is a two-stage pipeline. An operation is presented with `in_valid` high for one cycle. Its result appears with `out_valid` two clock edges later, and a new operation may start on every cycle. Operands with a zero exponent count as zero, so denormals are flushed. Operands with an all-ones exponent count as infinity and are passed through. When the exponent leaves the representable range, the unit raises the overflow or underflow flag.

Top module: `fp32_addsub`

## Requirements
- R1: For normal operands with `op_sub`=0 the result is the sum a+b rounded to nearest, ties to even, in the 1/8/23 layout (value = (-1)^sign × 1.fraction × 2^(exponent-127)).
- R2: With `op_sub`=1 the result equals a + (b with bit 31 inverted).
- R3: The significand with the smaller exponent is shifted right by the exponent difference. Bits shifted out are kept as guard, round and sticky. An exact half-ulp remainder rounds toward the even fraction, and anything above a half rounds up.
- R4: A carry out of the significand addition shifts the sum right one place and raises the exponent by one before rounding. A rounding carry that overflows the significand does the same.
- R5: After cancellation the sum is shifted left until its leading one sits in the hidden-bit position, and the exponent drops by one for each place (0.5 − 0.4375 gives 0x3D800000).
- R6: A sum that is exactly zero yields +0 (0x00000000) with both flags low.
- R7: If the rounded exponent reaches 255, `overflow` is 1 and the result is infinity (exponent 0xFF, fraction 0) with the sign of the sum.
- R8: If the normalized exponent falls to 0 or below, `underflow` is 1 and the result is zero with the sign of the sum.
- R9: An operand whose exponent field is 0 is treated as zero, whatever its fraction.
- R10: An operand whose exponent field is 255 is treated as infinity. The result is infinity with operand a's sign if a is infinite, otherwise with b's effective sign, and both flags stay low.
- R11: `out_valid` rises exactly two clock edges after an accepted `in_valid`. Back-to-back inputs give results on consecutive cycles. Both flags are 0 whenever `out_valid` is 0.
- R12: During and right after reset, `out_valid`, `result`, `overflow` and `underflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 32 | Rounded result |
| overflow | output | 1 | Exponent overflow, result forced to infinity |
| underflow | output | 1 | Exponent underflow, result forced to zero |

## Verification
The hardest cases to reach are exact rounding ties and a rounding carry that spills into the exponent. These need operand pairs whose exponent gap puts a lone one exactly in the guard position. The stimulus table pairs 1.0 and 2^24 with an operand 24 binades lower, once with an even and once with an odd final fraction. It also adds half an ulp to the largest finite value, which makes the rounding increment itself overflow to infinity. Massive cancellation is reached by subtracting neighbouring values at the smallest normal exponent, and that case also drives the underflow path.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic [1:0] {
    CL_ZERO = 2'd0,
    CL_NORM = 2'd1,
    CL_INF  = 2'd2
  } opnd_class_e;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
  import fpa_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      expo,
  output logic [FRAC_W:0]       mant,
  output opnd_class_e           cls
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  logic [EXP_W-1:0]  e_fld;
  logic [FRAC_W-1:0] f_fld;

  assign sign  = word[EXP_W+FRAC_W];
  assign e_fld = word[EXP_W+FRAC_W-1:FRAC_W];
  assign f_fld = word[FRAC_W-1:0];

  always_comb begin
    if (e_fld == '0) begin
      cls  = CL_ZERO;
      expo = '0;
      mant = '0;
    end else if (e_fld == EXP_ONES) begin
      cls  = CL_INF;
      expo = e_fld;
      mant = {1'b1, f_fld};
    end else begin
      cls  = CL_NORM;
      expo = e_fld;
      mant = {1'b1, f_fld};
    end
  end
endmodule

// File: rtl/fpa_align_add.sv
module fpa_align_add #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                 sign_a,
  input  logic [EXP_W-1:0]     exp_a,
  input  logic [FRAC_W:0]      mant_a,
  input  logic                 sign_b,
  input  logic [EXP_W-1:0]     exp_b,
  input  logic [FRAC_W:0]      mant_b,
  output logic [FRAC_W+4:0]    sum,
  output logic [EXP_W-1:0]     exp_big,
  output logic [EXP_W-1:0]     exp_small,
  output logic                 sign_res
);
  localparam int MANT_W = FRAC_W + 1;
  localparam int WIDE   = MANT_W + 3;
  localparam int SUM_W  = WIDE + 1;

  logic              a_big, eff_sub;
  logic [MANT_W-1:0] m_big, m_small;
  logic [EXP_W-1:0]  gap;
  logic [WIDE-1:0]   ext_big, ext_small, shifted, lost, aligned;
  logic              sticky;

  assign a_big     = {exp_a, mant_a} >= {exp_b, mant_b};
  assign exp_big   = a_big ? exp_a : exp_b;
  assign exp_small = a_big ? exp_b : exp_a;
  assign m_big     = a_big ? mant_a : mant_b;
  assign m_small   = a_big ? mant_b : mant_a;
  assign sign_res  = a_big ? sign_a : sign_b;
  assign eff_sub   = sign_a ^ sign_b;
  assign gap       = exp_big - exp_small;

  assign ext_big   = {m_big, 3'b000};
  assign ext_small = {m_small, 3'b000};

  // right shift of the smaller operand; every dropped bit folds into sticky
  always_comb begin
    if (int'(gap) >= WIDE) begin
      shifted = '0;
      lost    = ext_small;
    end else begin
      shifted = ext_small >> gap;
      lost    = ext_small << (WIDE - int'(gap));
    end
    sticky  = |lost;
    aligned = {shifted[WIDE-1:1], shifted[0] | sticky};
  end

  assign sum = eff_sub ? ({1'b0, ext_big} - {1'b0, aligned})
                       : ({1'b0, ext_big} + {1'b0, aligned});

  always_comb begin
    assert_align_order_R3: assert (exp_big >= exp_small)
      else $error("alignment picked the smaller exponent");
  end
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W+4:0]     sum,
  input  logic [EXP_W-1:0]      expo,
  input  logic                  sign,
  input  logic                  inf_in,
  input  logic                  inf_sign,
  output logic [EXP_W+FRAC_W:0] word,
  output logic                  ovf,
  output logic                  unf
);
  localparam int MANT_W = FRAC_W + 1;
  localparam int WIDE   = MANT_W + 3;
  localparam int SUM_W  = WIDE + 1;
  localparam int EW2    = EXP_W + 2;
  localparam int LZ_W   = $clog2(WIDE + 1);
  localparam logic signed [EW2-1:0] EXP_TOP = EW2'((1 << EXP_W) - 1);

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [WIDE-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(WIDE);
    for (int i = 0; i < WIDE; i++) begin
      if (v[i]) n = LZ_W'(WIDE - 1 - i);
    end
    return n;
  endfunction

  logic [LZ_W-1:0]       lz;
  logic [WIDE-1:0]       m;
  logic signed [EW2-1:0] e_norm, e_fin;
  logic [MANT_W-1:0]     keep;
  logic                  g, r, s, up;
  logic [MANT_W:0]       rnd;
  logic [FRAC_W-1:0]     frac;

  assign lz = lead_zeros(sum[WIDE-1:0]);

  // normalize: carry shifts right, cancellation shifts left
  always_comb begin
    if (sum[SUM_W-1]) begin
      m      = {sum[SUM_W-1:2], sum[1] | sum[0]};
      e_norm = $signed({2'b00, expo}) + EW2'(1);
    end else begin
      m      = sum[WIDE-1:0] << lz;
      e_norm = $signed({2'b00, expo}) - $signed(EW2'(lz));
    end
  end

  // round to nearest, ties to even
  assign keep = m[WIDE-1:3];
  assign g    = m[2];
  assign r    = m[1];
  assign s    = m[0];
  assign up   = g & (r | s | keep[0]);
  assign rnd  = {1'b0, keep} + (MANT_W+1)'(up);

  always_comb begin
    if (rnd[MANT_W]) begin
      e_fin = e_norm + EW2'(1);
      frac  = rnd[FRAC_W:1];
    end else begin
      e_fin = e_norm;
      frac  = rnd[FRAC_W-1:0];
    end
  end

  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    if (inf_in) begin
      word = {inf_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (sum == '0) begin
      word = '0;
    end else if (e_norm <= 0) begin
      unf  = 1'b1;
      word = {sign, {(EXP_W+FRAC_W){1'b0}}};
    end else if (e_fin >= EXP_TOP) begin
      ovf  = 1'b1;
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      word = {sign, e_fin[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fpa_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  input  logic                      op_sub,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      overflow,
  output logic                      underflow
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int SUM_W  = MANT_W + 4;

  logic [WORD_W-1:0] opnd [2];
  logic              u_sign [2];
  logic [EXP_W-1:0]  u_exp  [2];
  logic [MANT_W-1:0] u_mant [2];
  opnd_class_e       u_cls  [2];

  assign opnd[0] = op_a;
  assign opnd[1] = {op_b[WORD_W-1] ^ op_sub, op_b[WORD_W-2:0]};  // R2

  for (genvar k = 0; k < 2; k++) begin : g_unpack
    fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .word (opnd[k]),
      .sign (u_sign[k]),
      .expo (u_exp[k]),
      .mant (u_mant[k]),
      .cls  (u_cls[k])
    );
  end

  logic [SUM_W-1:0] al_sum;
  logic [EXP_W-1:0] al_exp_big, al_exp_small;
  logic             al_sign;

  fpa_align_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align_add (
    .sign_a    (u_sign[0]),
    .exp_a     (u_exp[0]),
    .mant_a    (u_mant[0]),
    .sign_b    (u_sign[1]),
    .exp_b     (u_exp[1]),
    .mant_b    (u_mant[1]),
    .sum       (al_sum),
    .exp_big   (al_exp_big),
    .exp_small (al_exp_small),
    .sign_res  (al_sign)
  );

  logic a_inf, b_inf, any_inf, inf_sgn;
  assign a_inf   = (u_cls[0] == CL_INF);
  assign b_inf   = (u_cls[1] == CL_INF);
  assign any_inf = a_inf | b_inf;
  assign inf_sgn = a_inf ? u_sign[0] : u_sign[1];   // R10

  // stage A: aligned sum
  logic             vld_a, inf_a, inf_sgn_a, sign_a_q;
  logic [SUM_W-1:0] sum_a;
  logic [EXP_W-1:0] exp_a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_a     <= 1'b0;
      inf_a     <= 1'b0;
      inf_sgn_a <= 1'b0;
      sign_a_q  <= 1'b0;
      sum_a     <= '0;
      exp_a_q   <= '0;
    end else begin
      vld_a     <= in_valid;
      inf_a     <= any_inf;
      inf_sgn_a <= inf_sgn;
      sign_a_q  <= al_sign;
      sum_a     <= al_sum;
      exp_a_q   <= al_exp_big;
    end
  end

  logic [WORD_W-1:0] nr_word;
  logic              nr_ovf, nr_unf;
  logic              sum_is_zero;
  assign sum_is_zero = (sum_a == '0) & ~inf_a;

  fpa_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm_round (
    .sum      (sum_a),
    .expo     (exp_a_q),
    .sign     (sign_a_q),
    .inf_in   (inf_a),
    .inf_sign (inf_sgn_a),
    .word     (nr_word),
    .ovf      (nr_ovf),
    .unf      (nr_unf)
  );

  // stage B: packed result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      out_valid <= vld_a;
      result    <= nr_word;
      overflow  <= vld_a & nr_ovf;
      underflow <= vld_a & nr_unf;
    end
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid)
    else $error("result valid did not follow input by two edges");

  assert_quiet_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!overflow && !underflow))
    else $error("flag raised without a valid result");

  assert_ovf_inf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}))
    else $error("overflow without infinity result");

  assert_unf_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (result[WORD_W-2:0] == '0))
    else $error("underflow without zero result");

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow))
    else $error("both range flags raised");

  assert_exact_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_a && sum_is_zero) |=> (result == '0 && !overflow && !underflow))
    else $error("exact zero sum not packed as +0");
endmodule

// File: tb/fp32_addsub_tb.sv
module fp32_addsub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        op_sub = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        overflow, underflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;  // 125 MHz

  fp32_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
    .out_valid(out_valid), .result(result),
    .overflow(overflow), .underflow(underflow)
  );

  // {a, b, sub, expected, ovf, unf, requirement number}
  localparam int NV = 20;
  localparam logic [106:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0, 8'd1},  // R1 1+1
    {32'hBF800000, 32'h3F800000, 1'b1, 32'hC0000000, 1'b0, 1'b0, 8'd2},  // R2 -1-1
    {32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0, 1'b0, 8'd2},  // R2 3-1
    {32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd3},  // R3 tie to even, down
    {32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, 8'd3},  // R3 tie to even, up
    {32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 1'b0, 1'b0, 8'd3},  // R3 above half
    {32'h4B800000, 32'h3F800000, 1'b0, 32'h4B800000, 1'b0, 1'b0, 8'd3},  // R3 2^24+1 tie
    {32'h3FFFFFFF, 32'h3F800000, 1'b0, 32'h40400000, 1'b0, 1'b0, 8'd4},  // R4 carry then round
    {32'h3F000000, 32'hBEE00000, 1'b0, 32'h3D800000, 1'b0, 1'b0, 8'd5},  // R5 0.5-0.4375
    {32'h3FC00000, 32'h3FC00000, 1'b1, 32'h00000000, 1'b0, 1'b0, 8'd6},  // R6 x-x
    {32'hBFC00000, 32'h3FC00000, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'd6},  // R6 -x+x
    {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, 8'd7},  // R7 max+max
    {32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0, 8'd7},  // R7 rounding overflow
    {32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1, 8'd8},  // R8 underflow
    {32'h3F800000, 32'h00400000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd9},  // R9 denormal b
    {32'h00000000, 32'hBF800000, 1'b0, 32'hBF800000, 1'b0, 1'b0, 8'd9},  // R9 zero a
    {32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, 8'd10}, // R10 +inf a
    {32'hFF800000, 32'h7F800000, 1'b0, 32'hFF800000, 1'b0, 1'b0, 8'd10}, // R10 a wins
    {32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0, 8'd10}, // R10 b flipped
    {32'h40000000, 32'h3F800000, 1'b0, 32'h40400000, 1'b0, 1'b0, 8'd1}   // R1 2+1
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int w = 0; w < 8 && !out_valid; w++) @(negedge clk);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12 result", result, 32'd0);
    chk("R12 flags", {30'd0, overflow, underflow}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after release", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [106:0] v;
      v = VEC[i];
      run_op(v[106:75], v[74:43], v[42]);
      checks++;
      if (!out_valid || result !== v[41:10] || overflow !== v[9] || underflow !== v[8]) begin
        failures++;
        $display("FAIL R%0d vec%0d actual=%08h o%0b u%0b v%0b expected=%08h o%0b u%0b",
                 v[7:0], i, result, overflow, underflow, out_valid, v[41:10], v[9], v[8]);
      end
    end

    // R11 exact latency and back-to-back throughput
    @(negedge clk);
    op_a = 32'h3F800000; op_b = 32'h3F800000; op_sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    op_a = 32'h40400000; op_b = 32'h3F800000; op_sub = 1'b1;
    chk("R11 not early", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 first valid", {31'd0, out_valid}, 32'd1);
    chk("R11 first result", result, 32'h40000000);
    @(negedge clk);
    chk("R11 second valid", {31'd0, out_valid}, 32'd1);
    chk("R11 second result", result, 32'h40000000);
    @(negedge clk);
    chk("R11 drops", {31'd0, out_valid}, 32'd0);
    chk("R11 flags idle", {30'd0, overflow, underflow}, 32'd0);

    // R7 flag clears on the next plain operation
    run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0);
    chk("R7 overflow set", {31'd0, overflow}, 32'd1);
    run_op(32'h3F800000, 32'h3F800000, 1'b0);
    chk("R7 overflow cleared", {31'd0, overflow}, 32'd0);

    // R12 reset mid-stream
    @(negedge clk);
    op_a = 32'h7F7FFFFF; op_b = 32'h7F7FFFFF; in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R12 reset result", result, 32'd0);
    chk("R12 reset valid", {30'd0, out_valid, overflow}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule